// File: doc/BRIEF.md
# Autoboot External ROM Loader

This block copies application code out of a byte-wide external ROM into internal program memory right after reset. The ROM hangs off a shared 8-bit bus that carries both address and data, with external address latches in front of it. When reset is released, the loader reads the boot strap pins once and decides whether to run. If it runs, it fetches one byte at a time. For each byte it drives three address bytes, clocked into the latches by rising edges of one output-enable strobe. It then releases the bus for a fourth strobe pulse while the memory select is low, so the ROM can return the byte. The loader captures that byte and writes it through an internal write port.

A latched byte count ends the download. The loader then raises a done flag, frees the bus and lets the shared interrupt pin work as an open-drain interrupt request. A latched phase length sets how many clock cycles each strobe level lasts, so that slow latches and slow ROMs can keep up.

Top module: `rom_boot_loader`

## Requirements
- R1: The straps are sampled once, at the first rising clock edge with `rst_n` high. A download starts only if `strap_boot_n` is 0 and {`strap_wr`,`strap_rd`} is 2'b01 or 2'b10, which are the two serial host modes. `strap_par` has no effect on this decision.
- R2: When no download starts (boot strap high, or {wr,rd} = 2'b00 or 2'b11), the outputs stay at rest until the next reset: `mem_oe_n`=1, `mem_sel_n`=1, `bus_oe`=0, no `wr_en` pulse, and `boot_active`=0, `boot_done`=0, `irq_pull`=0.
- R3: Each byte fetch starts with three low pulses of `mem_oe_n` during which `bus_oe`=1. The bus carries, in this order, the address bits 23:16 (always 8'h00 for the 15-bit address), then {1'b0, address[14:8]}, then address[7:0]. Each value is stable across the rising strobe edge that latches it.
- R4: The fourth low pulse of each fetch is the read pulse. During the whole of that pulse `bus_oe`=0 and `mem_sel_n`=0. At no other time does `mem_sel_n` go low, and `bus_oe` is never 1 while `mem_sel_n` is 0.
- R5: `bus_in` is captured on the clock edge at which `mem_oe_n` rises at the end of the read pulse. In the next cycle `wr_en` is high for exactly one cycle, carrying `wr_data` = the captured byte and `wr_addr` = the byte index, which counts up from 0.
- R6: Every low level and every high level of `mem_oe_n` during a download lasts max(`cfg_phase`,2) clock cycles. The first falling edge is visible in the cycle right after the sampling edge.
- R7: After `cfg_len` bytes (valid range 1 to 32768), `boot_done` rises 1 + `cfg_len`*8*max(`cfg_phase`,2) rising edges after reset release. `boot_done` then stays high until reset, with `bus_oe`=0, `mem_oe_n`=1 and `mem_sel_n`=1.
- R8: `mem_wr_n` stays 1 at all times.
- R9: `irq_pull` (open-drain pull-low of the shared boot/interrupt pin) is 1 only when `boot_done`=1 and `irq_req`=1. It is never 1 during strap sampling or during the download.
- R10: `cfg_len` and `cfg_phase` are latched at the sampling edge. Changes to them during the download have no effect on its timing or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the straps are sampled when it is released |
| strap_boot_n | input | 1 | Level of the shared boot/interrupt pin (0 requests a download) |
| strap_wr | input | 1 | Host-mode strap, write side |
| strap_rd | input | 1 | Host-mode strap, read side |
| strap_par | input | 1 | Parallel-mode select strap, ignored by this block |
| cfg_len | input | 16 | Number of bytes to load (1..32768) |
| cfg_phase | input | 4 | Cycles per strobe level (values below 2 act as 2) |
| bus_out | output | 8 | Address byte driven onto the shared bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| bus_in | input | 8 | Data read back from the shared bus |
| mem_oe_n | output | 1 | Output-enable strobe: latch clock and ROM read enable |
| mem_sel_n | output | 1 | External memory select, active low |
| mem_wr_n | output | 1 | External memory write strobe, held high |
| wr_en | output | 1 | Internal memory write pulse |
| wr_addr | output | 15 | Internal memory write address |
| wr_data | output | 8 | Internal memory write data |
| boot_active | output | 1 | High while the download runs |
| boot_done | output | 1 | High once the download has finished |
| irq_req | input | 1 | Internal interrupt request |
| irq_pull | output | 1 | Pull the shared interrupt pin low |

## Verification
The first strobe fall is due one cycle after reset release. The bench checks for it at the falling clock edge after the first rising edge. `boot_done` is due exactly 1 + len*8*P rising edges after release. The bench counts rising edges and compares that count with the value it computes. Each write pulse comes in the cycle after its read strobe rises, so a monitor samples it at falling edges and compares address and data against a model of the ROM placed behind model latches. Strobe level widths, bus ownership and the interrupt pin are checked at every falling edge, away from the edge where the design updates.

// File: rtl/boot_pkg.sv
package boot_pkg;
   typedef enum logic [1:0] {
      ST_SAMPLE = 2'd0,
      ST_FETCH  = 2'd1,
      ST_OFF    = 2'd2,
      ST_DONE   = 2'd3
   } boot_state_t;

   // Serial host modes: {wr,rd} = 01 or 10
   function automatic logic serial_mode(input logic wr, input logic rd);
      return wr ^ rd;
   endfunction
endpackage

// File: rtl/boot_strobe_seq.sv
module boot_strobe_seq #(
   parameter int PH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PH_W-1:0] ph_len,
   output logic            strobe_low,
   output logic [1:0]      pulse_idx,
   output logic            rd_rise,
   output logic            byte_end
);
   logic [PH_W-1:0] cnt;
   logic            half;
   logic [1:0]      pulse;
   logic            last;

   assign last = (cnt == ph_len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         half  <= 1'b0;
         pulse <= 2'd0;
      end else if (!run) begin
         cnt   <= '0;
         half  <= 1'b0;
         pulse <= 2'd0;
      end else if (last) begin
         cnt <= '0;
         if (!half) begin
            half <= 1'b1;
         end else begin
            half  <= 1'b0;
            pulse <= pulse + 2'd1;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign strobe_low = run && !half;
   assign pulse_idx  = pulse;
   assign rd_rise    = run && !half && last && (pulse == 2'd3);
   assign byte_end   = run && half && last && (pulse == 2'd3);

   // R6
   low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_low) |=> strobe_low);
endmodule

// File: rtl/boot_addr_ctr.sv
module boot_addr_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] count,
   output logic             at_end
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc)
         count <= count + 1'b1;
   end

   assign at_end = (count == len);

   // R7
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (count <= len));
endmodule

// File: rtl/rom_boot_loader.sv
module rom_boot_loader #(
   parameter int ADDR_W = 15,
   parameter int PH_W   = 4,
   parameter int LEN_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_boot_n,
   input  logic              strap_wr,
   input  logic              strap_rd,
   input  logic              strap_par,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [PH_W-1:0]   cfg_phase,
   output logic [7:0]        bus_out,
   output logic              bus_oe,
   input  logic [7:0]        bus_in,
   output logic              mem_oe_n,
   output logic              mem_sel_n,
   output logic              mem_wr_n,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              boot_active,
   output logic              boot_done,
   input  logic              irq_req,
   output logic              irq_pull
);
   import boot_pkg::*;

   localparam int BUS_AW = 24;
   localparam int PAD_W  = BUS_AW - ADDR_W;
   localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << ADDR_W;
   localparam logic [PH_W-1:0]  MIN_PH  = PH_W'(2);

   if (ADDR_W < 9 || ADDR_W > BUS_AW) begin : g_bad_addr
      $error("ADDR_W must lie in 9..24");
   end
   if (PH_W < 2) begin : g_bad_ph
      $error("PH_W must be at least 2");
   end
   if (LEN_W != ADDR_W + 1) begin : g_bad_len
      $error("LEN_W must be ADDR_W+1");
   end

   boot_state_t      state;
   logic [LEN_W-1:0] len_q;
   logic [PH_W-1:0]  ph_q;
   logic             run;
   logic             strobe_low;
   logic [1:0]       pulse_idx;
   logic             rd_rise;
   logic             byte_end;
   logic [LEN_W-1:0] count;
   logic             at_end;
   logic [BUS_AW-1:0] addr24;
   logic             par_unused;

   assign par_unused = strap_par;
   assign run = (state == ST_FETCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_SAMPLE;
         len_q <= MAX_LEN;
         ph_q  <= MIN_PH;
      end else begin
         case (state)
            ST_SAMPLE: begin
               len_q <= (cfg_len == '0 || cfg_len > MAX_LEN) ? MAX_LEN : cfg_len;
               ph_q  <= (cfg_phase < MIN_PH) ? MIN_PH : cfg_phase;
               if (!strap_boot_n && serial_mode(strap_wr, strap_rd))
                  state <= ST_FETCH;
               else
                  state <= ST_OFF;
            end
            ST_FETCH: if (byte_end && at_end) state <= ST_DONE;
            default: state <= state;
         endcase
      end
   end

   boot_strobe_seq #(.PH_W(PH_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .ph_len     (ph_q),
      .strobe_low (strobe_low),
      .pulse_idx  (pulse_idx),
      .rd_rise    (rd_rise),
      .byte_end   (byte_end)
   );

   boot_addr_ctr #(.CNT_W(LEN_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (state == ST_SAMPLE),
      .inc    (rd_rise),
      .len    (len_q),
      .count  (count),
      .at_end (at_end)
   );

   if (PAD_W > 0) begin : g_pad
      assign addr24 = {{PAD_W{1'b0}}, count[ADDR_W-1:0]};
   end else begin : g_full
      assign addr24 = count[ADDR_W-1:0];
   end

   always_comb begin
      case (pulse_idx)
         2'd0:    bus_out = addr24[23:16];
         2'd1:    bus_out = addr24[15:8];
         2'd2:    bus_out = addr24[7:0];
         default: bus_out = 8'h00;
      endcase
   end

   assign bus_oe    = run && (pulse_idx != 2'd3);
   assign mem_oe_n  = !strobe_low;
   assign mem_sel_n = !(run && (pulse_idx == 2'd3));
   assign mem_wr_n  = 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= 8'h00;
      end else begin
         wr_en <= rd_rise;
         if (rd_rise) begin
            wr_addr <= count[ADDR_W-1:0];
            wr_data <= bus_in;
         end
      end
   end

   assign boot_active = run;
   assign boot_done   = (state == ST_DONE);
   assign irq_pull    = boot_done && irq_req;

   // R5
   capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (mem_oe_n && $past(!mem_oe_n) && $past(!mem_sel_n)));
   // R5
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
   // R9
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pull |-> boot_done);
   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> (boot_done && mem_sel_n && !bus_oe));
   // R4
   bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_sel_n) |-> (!bus_oe && !mem_oe_n));
endmodule

// File: tb/sim_rom_boot_loader.sv
module sim_rom_boot_loader;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap_boot_n = 1'b1, strap_wr = 1'b0, strap_rd = 1'b1, strap_par = 1'b0;
   logic [15:0] cfg_len = 16'd1;
   logic [3:0]  cfg_phase = 4'd2;
   logic [7:0]  bus_out, bus_in;
   logic bus_oe, mem_oe_n, mem_sel_n, mem_wr_n, wr_en, boot_active, boot_done;
   logic [14:0] wr_addr;
   logic [7:0]  wr_data;
   logic irq_req = 1'b1;
   logic irq_pull;

   int checks = 0, fails = 0;
   int exp_idx = 0, wr_err = 0, tim_err = 0, bus_err = 0;
   int seg_len = 0;
   logic prev_oe_n = 1'b1, seen_low = 1'b0;
   int peff_mon = 2;
   logic [7:0] lat_hi = 8'hAA, lat_mid = 8'hAA, lat_lo = 8'hAA;

   always #(CLK_P/2) clk = ~clk;

   rom_boot_loader u0 (
      .clk(clk), .rst_n(rst_n), .strap_boot_n(strap_boot_n), .strap_wr(strap_wr),
      .strap_rd(strap_rd), .strap_par(strap_par), .cfg_len(cfg_len), .cfg_phase(cfg_phase),
      .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .mem_oe_n(mem_oe_n),
      .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .boot_active(boot_active), .boot_done(boot_done),
      .irq_req(irq_req), .irq_pull(irq_pull)
   );

   function automatic logic [7:0] rom(input logic [14:0] a);
      return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h3C;
   endfunction

   // external latch model
   always @(posedge mem_oe_n) begin
      if (bus_oe) begin
         lat_hi  <= lat_mid;
         lat_mid <= lat_lo;
         lat_lo  <= bus_out;
      end
   end
   assign bus_in = (!mem_sel_n && !mem_oe_n) ? rom({lat_mid[6:0], lat_lo}) : 8'hFF;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            if (wr_addr != exp_idx[14:0] || wr_data != rom(exp_idx[14:0]) || lat_hi != 8'h00)
               wr_err++;
            exp_idx++;
         end
         if (mem_oe_n != prev_oe_n) begin
            if (!prev_oe_n) begin
               if (seg_len != peff_mon) tim_err++;
            end else if (seen_low) begin
               if (seg_len != peff_mon) tim_err++;
            end
            if (!mem_oe_n) seen_low = 1'b1;
            seg_len = 1;
         end else begin
            seg_len++;
         end
         prev_oe_n = mem_oe_n;
         if ((bus_oe && !mem_sel_n) || !mem_wr_n || (irq_pull && !boot_done) ||
             (!mem_sel_n && !(!boot_active)) == 1'b0 && !mem_sel_n)
            bus_err++;
      end
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic start(input logic bn, input logic w, input logic r, input logic p,
                        input int len, input int ph);
      @(negedge clk);
      rst_n = 1'b0;
      strap_boot_n = bn; strap_wr = w; strap_rd = r; strap_par = p;
      cfg_len = 16'(len); cfg_phase = 4'(ph);
      irq_req = 1'b1;
      peff_mon = (ph < 2) ? 2 : ph;
      repeat (2) @(negedge clk);
      exp_idx = 0; wr_err = 0; tim_err = 0; bus_err = 0;
      seen_low = 1'b0; seg_len = 0; prev_oe_n = 1'b1;
      rst_n = 1'b1;
   endtask

   task automatic run_idle(input logic bn, input logic w, input logic r, input string tag);
      start(bn, w, r, 1'b0, 4, 2);
      repeat (40) @(negedge clk);
      chk(exp_idx == 0 && !boot_active && !boot_done, {tag, " no download"}, exp_idx, 0);
      chk(mem_oe_n && mem_sel_n && !bus_oe && !irq_pull, {tag, " bus at rest"},
          {mem_oe_n, mem_sel_n, bus_oe, irq_pull}, 4'b1100);
   endtask

   task automatic run_boot(input logic w, input logic r, input logic p, input int len,
                           input int ph, input logic disturb);
      int n = 0;
      int peff = (ph < 2) ? 2 : ph;
      int exp_n = 1 + len * 8 * peff;
      start(1'b0, w, r, p, len, ph);
      @(posedge clk); n = 1;
      @(negedge clk);
      // R6 first strobe fall one cycle after sampling edge; R1 download started
      chk(!mem_oe_n && boot_active, "R6 R1 first strobe fall", mem_oe_n, 0);
      if (disturb) begin
         cfg_len = 16'(len + 7);
         cfg_phase = 4'(peff + 2);
      end
      while (!boot_done && n < 150000) begin
         @(posedge clk); n++;
         @(negedge clk);
      end
      // R7 R10 done timing
      chk(n == exp_n, disturb ? "R10 done timing after cfg change" : "R7 done timing", n, exp_n);
      chk(exp_idx == len, "R5 write count", exp_idx, len);
      chk(wr_err == 0, "R5 R3 write address/data", wr_err, 0);
      chk(tim_err == 0, "R6 strobe level widths", tim_err, 0);
      chk(bus_err == 0, "R4 R8 R9 bus ownership", bus_err, 0);
      repeat (5) @(negedge clk);
      chk(boot_done && !bus_oe && mem_oe_n && mem_sel_n && exp_idx == len,
          "R7 released after done", {boot_done, bus_oe, mem_oe_n, mem_sel_n}, 4'b1011);
      irq_req = 1'b0; #1;
      chk(!irq_pull, "R9 no pull without request", irq_pull, 0);
      irq_req = 1'b1; #1;
      chk(irq_pull, "R9 pull after done", irq_pull, 1);
   endtask

   initial begin
      #(CLK_P * 190000);
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int unsigned seed = $urandom(32'd4711);
      seed = seed;
      repeat (3) @(negedge clk);
      // R2 reset state
      chk(mem_oe_n && mem_sel_n && !bus_oe && !wr_en && !boot_done && !irq_pull,
          "R2 reset state", {mem_oe_n, mem_sel_n, bus_oe}, 3'b110);
      chk(mem_wr_n, "R8 write strobe high", mem_wr_n, 1);
      run_idle(1'b1, 1'b0, 1'b1, "R2 R1 boot strap high");
      run_idle(1'b0, 1'b1, 1'b1, "R2 R1 parallel mode 11");
      run_idle(1'b0, 1'b0, 1'b0, "R2 R1 parallel mode 00");
      run_boot(1'b0, 1'b1, 1'b1, 3, 2, 1'b0);  // R1 strap_par high ignored
      run_boot(1'b1, 1'b0, 1'b0, 1, 0, 1'b0);  // R6 phase 0 acts as 2
      run_boot(1'b0, 1'b1, 1'b0, 5, 3, 1'b1);  // R10 cfg changed mid-run
      for (int i = 0; i < 4; i++) begin
         logic m = 1'($urandom_range(0, 1));
         run_boot(m, ~m, 1'($urandom_range(0, 1)), int'($urandom_range(2, 20)),
                  int'($urandom_range(2, 5)), 1'b0);
      end
      run_boot(1'b1, 1'b0, 1'b0, 600, 2, 1'b0);  // R3 upper address byte in use
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule